// File: doc/BRIEF.md
# Redundant Residue Arithmetic Unit

This block adds or multiplies two operands held as redundant residue vectors. Each vector has six channels: four information channels with moduli 199, 233, 194 and 239, and two check channels with moduli 251 and 509. Each channel computes its result modulo its own modulus. There are no carries between channels, so a fault in one channel's logic leaves the other five results correct. Error detection, error correction and conversion back to binary are done downstream.

An operand pair is applied together with an operation select and a valid strobe. The result vector appears a fixed number of cycles later, set by the `STAGES` parameter (1 or 2, default 2), and `out_valid` marks it. Operand residues at or above their modulus are folded into range before the operation.

Top module: `rrns_alu`

## Requirements
- R1: Operands and results are packed vectors of 49 bits. Channel 0 (modulus 199) uses bits [7:0], channel 1 (233) bits [15:8], channel 2 (194) bits [23:16], channel 3 (239) bits [31:24], channel 4 (251) bits [39:32] and channel 5 (509, 9 bits wide) bits [48:40].
- R2: With `op` = 0, each result channel equals (a_i + b_i) mod m_i.
- R3: With `op` = 1, each result channel equals (a_i × b_i) mod m_i.
- R4: An operand residue greater than or equal to its modulus, up to the all-ones value of its field, is first replaced by its remainder modulo m_i. It is never rejected.
- R5: Every result channel delivered with `out_valid` is strictly less than its modulus.
- R6: A result channel depends only on that channel's operand fields. Changing one channel's operands leaves every other result channel unchanged.
- R7: `out_valid` equals `in_valid` delayed by exactly `STAGES` clock cycles. While no new result arrives, `y` holds the last delivered result.
- R8: The reset is synchronous and active high. The cycle after reset has been sampled, `out_valid` is 0 and `y` is all zeros, and any operations still in flight are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks an operand pair to process |
| op | input | 1 | 0 selects add, 1 selects multiply |
| a | input | 49 | First operand residue vector |
| b | input | 49 | Second operand residue vector |
| out_valid | output | 1 | Marks a result on `y` |
| y | output | 49 | Result residue vector (registered) |

## Verification
An operand pair driven at a falling edge reaches `y` and `out_valid` exactly `STAGES` rising edges later, which is two edges at the default. Reset clears the outputs at the first rising edge that samples it. The bench queues one expected entry for every cycle it drives and pre-loads `STAGES` idle entries after each reset. At every falling edge it pops the entry that was queued `STAGES` cycles earlier and compares it with the outputs. A cycle without a valid result must show `out_valid` low and the previous result held on `y`.

// File: rtl/rrns_pkg.sv
package rrns_pkg;

  localparam int NCH = 6;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_MUL = 1'b1
  } rrns_op_e;

  // Channel moduli: information channels first, check channels last.
  function automatic int ch_mod(input int idx);
    case (idx)
      0:       return 199;
      1:       return 233;
      2:       return 194;
      3:       return 239;
      4:       return 251;
      default: return 509;
    endcase
  endfunction

  function automatic int ch_width(input int idx);
    return $clog2(ch_mod(idx));
  endfunction

  function automatic int ch_offset(input int idx);
    int acc;
    acc = 0;
    for (int k = 0; k < idx; k++) acc += ch_width(k);
    return acc;
  endfunction

  localparam int VEC_W = ch_offset(NCH);

endpackage

// File: rtl/rrns_modred.sv
// Constant-modulus reduction: multiply by a precomputed reciprocal, then
// apply at most two correcting subtractions.
module rrns_modred #(
  parameter int M  = 199,
  parameter int XW = 16
) (
  input  logic [XW-1:0]          x,
  output logic [$clog2(M)-1:0]   r
);

  localparam int MW = $clog2(M);
  localparam int K  = XW + MW;
  localparam int PW = XW + K + 1;
  localparam logic [PW-1:0] RECIP = PW'((64'd1 << K) / 64'(M));
  localparam logic [PW-1:0] MODW  = PW'(M);

  logic [PW-1:0] prod;
  logic [PW-1:0] quo;
  logic [PW-1:0] rem;
  logic          unused_hi;

  always_comb begin
    prod = PW'(x) * RECIP;
    quo  = prod >> K;
    rem  = PW'(x) - quo * MODW;
    if (rem >= MODW) rem = rem - MODW;
    if (rem >= MODW) rem = rem - MODW;
  end

  assign r         = rem[MW-1:0];
  assign unused_hi = ^rem[PW-1:MW];

endmodule

// File: rtl/rrns_vpipe.sv
// Valid shift register; exposes the enable of every data stage.
module rrns_vpipe #(
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vin,
  output logic [STAGES-1:0] stage_en,
  output logic              vout
);

  logic [STAGES-1:0] v_q;

  always_ff @(posedge clk) begin
    if (rst) v_q <= '0;
    else     v_q <= {v_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], vin} & {STAGES{1'b1}};
  end

  assign stage_en[0] = vin;
  generate
    for (genvar k = 1; k < STAGES; k++) begin : g_en
      assign stage_en[k] = v_q[k-1];
    end
  endgenerate

  assign vout = v_q[STAGES-1];

endmodule

// File: rtl/rrns_lane.sv
// One residue channel: fold operands, add or multiply, reduce, register.
module rrns_lane
  import rrns_pkg::*;
#(
  parameter int M      = 199,
  parameter int STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [STAGES-1:0]     stage_en,
  input  logic                  op,
  input  logic [$clog2(M)-1:0]  a,
  input  logic [$clog2(M)-1:0]  b,
  output logic [$clog2(M)-1:0]  y
);

  localparam int MW = $clog2(M);
  localparam int RW = 2 * MW;

  logic [MW-1:0] a_red, b_red, res;
  logic [RW-1:0] raw;

  rrns_modred #(.M(M), .XW(MW)) u_fold_a (.x(a), .r(a_red));
  rrns_modred #(.M(M), .XW(MW)) u_fold_b (.x(b), .r(b_red));

  always_comb begin
    if (op == OP_MUL) raw = RW'(a_red) * RW'(b_red);
    else              raw = RW'(a_red) + RW'(b_red);
  end

  generate
    if (STAGES >= 2) begin : g_two
      logic [RW-1:0] raw_q;
      always_ff @(posedge clk) begin
        if (rst)              raw_q <= '0;
        else if (stage_en[0]) raw_q <= raw;
      end
      rrns_modred #(.M(M), .XW(RW)) u_final (.x(raw_q), .r(res));
    end else begin : g_one
      rrns_modred #(.M(M), .XW(RW)) u_final (.x(raw), .r(res));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                     y <= '0;
    else if (stage_en[STAGES-1]) y <= res;
  end

endmodule

// File: rtl/rrns_alu.sv
module rrns_alu
  import rrns_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             op,
  input  logic [VEC_W-1:0] a,
  input  logic [VEC_W-1:0] b,
  output logic             out_valid,
  output logic [VEC_W-1:0] y
);

  logic [STAGES-1:0] stage_en;

  rrns_vpipe #(.STAGES(STAGES)) u_vpipe (
    .clk      (clk),
    .rst      (rst),
    .vin      (in_valid),
    .stage_en (stage_en),
    .vout     (out_valid)
  );

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      localparam int OF = ch_offset(g);
      localparam int W  = ch_width(g);
      rrns_lane #(.M(ch_mod(g)), .STAGES(STAGES)) u_lane (
        .clk      (clk),
        .rst      (rst),
        .stage_en (stage_en),
        .op       (op),
        .a        (a[OF +: W]),
        .b        (b[OF +: W]),
        .y        (y[OF +: W])
      );
    end
  endgenerate

endmodule

// File: rtl/rrns_alu_chk.sv
module rrns_alu_chk
  import rrns_pkg::*;
#(
  parameter int STAGES = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             op,
  input logic [VEC_W-1:0] a,
  input logic [VEC_W-1:0] b,
  input logic             out_valid,
  input logic [VEC_W-1:0] y
);

  logic             dv  [STAGES];
  logic             dop [STAGES];
  logic [VEC_W-1:0] da  [STAGES];
  logic [VEC_W-1:0] db  [STAGES];
  logic             rst_seen_q = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) begin
        dv[k] <= 1'b0; dop[k] <= 1'b0; da[k] <= '0; db[k] <= '0;
      end
    end else begin
      dv[0] <= in_valid; dop[0] <= op; da[0] <= a; db[0] <= b;
      for (int k = 1; k < STAGES; k++) begin
        dv[k] <= dv[k-1]; dop[k] <= dop[k-1]; da[k] <= da[k-1]; db[k] <= db[k-1];
      end
    end
  end

  function automatic int expect_res(input int m, input int x, input int z, input logic mul);
    int xr, zr;
    xr = x % m;
    zr = z % m;
    return mul ? (xr * zr) % m : (xr + zr) % m;
  endfunction

  // R7
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid == dv[STAGES-1]);

  always_ff @(posedge clk) rst_seen_q <= rst;

  // R8
  always_ff @(posedge clk) begin
    if (rst_seen_q) begin
      reset_clear_chk: assert (!out_valid && (y == '0));
    end
  end

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_lane
      localparam int OF = ch_offset(g);
      localparam int W  = ch_width(g);
      localparam int M  = ch_mod(g);

      // R5
      lane_range_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (int'(y[OF +: W]) < M));

      // R2 R3 R4 R6
      lane_value_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (int'(y[OF +: W]) ==
          expect_res(M, int'(da[STAGES-1][OF +: W]), int'(db[STAGES-1][OF +: W]),
                     dop[STAGES-1])));
    end
  endgenerate

endmodule

bind rrns_alu rrns_alu_chk #(.STAGES(STAGES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .op        (op),
  .a         (a),
  .b         (b),
  .out_valid (out_valid),
  .y         (y)
);

// File: tb/tb_rrns_alu.sv
module tb_rrns_alu;

  localparam int LAT = 2;
  localparam int VW  = 49;

  int MODS [6] = '{199, 233, 194, 239, 251, 509};
  int WID  [6] = '{8, 8, 8, 8, 8, 9};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          op = 1'b0;
  logic [VW-1:0] a = '0;
  logic [VW-1:0] b = '0;
  logic          out_valid;
  logic [VW-1:0] y;

  always #4 clk = ~clk;

  rrns_alu #(.STAGES(LAT)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .a(a), .b(b), .out_valid(out_valid), .y(y)
  );

  typedef struct {
    bit            v;
    logic [VW-1:0] y;
    string         tag;
  } exp_t;

  exp_t          expq[$];
  logic [VW-1:0] last_y = '0;
  int            n_chk = 0;
  int            n_fail = 0;
  int            ra [6];
  int            rb [6];
  bit            done = 0;

  function automatic int offs(input int i);
    int s;
    s = 0;
    for (int k = 0; k < i; k++) s += WID[k];
    return s;
  endfunction

  function automatic logic [VW-1:0] pack(input int v [6]);
    logic [VW-1:0] r;
    r = '0;
    for (int i = 0; i < 6; i++)
      r |= VW'(v[i] & ((1 << WID[i]) - 1)) << offs(i);
    return r;
  endfunction

  function automatic int lane_of(input logic [VW-1:0] v, input int i);
    return int'((v >> offs(i)) & VW'((1 << WID[i]) - 1));
  endfunction

  function automatic logic [VW-1:0] model(input bit mul);
    int e [6];
    for (int i = 0; i < 6; i++) begin
      int xr, zr;
      xr = ra[i] % MODS[i];
      zr = rb[i] % MODS[i];
      e[i] = mul ? (xr * zr) % MODS[i] : (xr + zr) % MODS[i];
    end
    return pack(e);
  endfunction

  task automatic check_out();
    exp_t e;
    e = expq.pop_front();
    n_chk++;
    if (out_valid !== e.v) begin
      n_fail++;
      $display("FAIL R7: out_valid=%0b expected %0b", out_valid, e.v);
    end
    if (e.v) last_y = e.y;
    n_chk++;
    if (y !== last_y) begin
      n_fail++;
      $display("FAIL %s: y=%h expected %h", e.v ? e.tag : "R7", y, last_y);
    end
    if (e.v) begin
      for (int i = 0; i < 6; i++) begin
        n_chk++;
        if (lane_of(y, i) >= MODS[i]) begin
          n_fail++;
          $display("FAIL R5: lane %0d=%0d expected below %0d", i, lane_of(y, i), MODS[i]);
        end
      end
    end
  endtask

  task automatic step(input bit v, input bit mul, input string tag);
    exp_t e;
    @(negedge clk);
    check_out();
    in_valid = v;
    op       = mul;
    a        = pack(ra);
    b        = pack(rb);
    e.v   = v;
    e.y   = v ? model(mul) : '0;
    e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic do_reset();
    exp_t e;
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    n_chk++;
    if (out_valid !== 1'b0 || y !== '0) begin
      n_fail++;
      $display("FAIL R8: out_valid=%0b y=%h expected 0 and %h", out_valid, y, {VW{1'b0}});
    end
    expq.delete();
    last_y = '0;
    e.v = 0; e.y = '0; e.tag = "R7";
    repeat (LAT) expq.push_back(e);
  endtask

  task automatic set_all(input int va, input int vb);
    for (int i = 0; i < 6; i++) begin ra[i] = va; rb[i] = vb; end
  endtask

  initial begin
    do_reset();

    // R2: zeros and largest in-range residues
    set_all(0, 0);
    step(1, 0, "R2");
    for (int i = 0; i < 6; i++) begin ra[i] = MODS[i] - 1; rb[i] = MODS[i] - 1; end
    step(1, 0, "R2");
    // R3: largest product per channel
    step(1, 1, "R3");

    // R4: all-ones fields and exact modulus values
    for (int i = 0; i < 6; i++) begin ra[i] = (1 << WID[i]) - 1; rb[i] = (1 << WID[i]) - 1; end
    step(1, 0, "R4");
    step(1, 1, "R4");
    for (int i = 0; i < 6; i++) begin ra[i] = MODS[i]; rb[i] = 5; end
    step(1, 1, "R4");
    step(1, 0, "R4");

    // R1: one active channel at a time lands in its own field
    for (int c = 0; c < 6; c++) begin
      set_all(0, 0);
      ra[c] = 1;
      rb[c] = 2;
      step(1, 0, "R1");
    end

    // R6: alter a single channel, all others must keep their results
    for (int i = 0; i < 6; i++) begin ra[i] = 17 + i; rb[i] = 40 + 3 * i; end
    step(1, 1, "R6");
    ra[5] = 500;
    step(1, 1, "R6");
    rb[2] = 193;
    step(1, 1, "R6");

    // R7: idle cycles hold the last result
    repeat (4) step(0, 0, "R7");

    // R2 R3 R5: mixed random traffic with gaps
    for (int n = 0; n < 400; n++) begin
      bit v, mul;
      for (int i = 0; i < 6; i++) begin
        ra[i] = $urandom_range(0, (1 << WID[i]) - 1);
        rb[i] = $urandom_range(0, (1 << WID[i]) - 1);
      end
      v   = ($urandom_range(0, 3) != 0);
      mul = $urandom_range(0, 1) == 1;
      step(v, mul, mul ? "R3" : "R2");
    end

    // R8: reset with operations in flight
    set_all(3, 4);
    step(1, 1, "R3");
    step(1, 0, "R2");
    do_reset();
    repeat (LAT + 2) step(0, 0, "R7");

    set_all(100, 150);
    step(1, 0, "R2");
    repeat (LAT + 1) step(0, 0, "R7");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R7: watchdog expired, actual still running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule